// File: doc/BRIEF.md
# Serial Configuration Memory Autoload Sequencer

After reset this block reads a fixed number of 16-bit words from a three-wire serial configuration memory and collects them into a wide register, such as a station address. No spare pins are needed for this. While the load runs, the three lowest packet-memory address pins are borrowed as serial clock, serial data towards the memory, and serial data from the memory. When the last word has arrived, a done flag rises and the pins go back to carrying packet-memory address bits 0 to 2.

A strap input chooses between a small device with a 6-bit word address and a large device with an 8-bit word address. The strap is sampled during reset. Once the load is complete, software can drive the three pins and the memory select line directly by bit-banging, and it can read the returned data bit. Only reads are issued. The loaded words are not interpreted here.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While `rst` is high, `ee_cs`, `pin_a0`, `pin_a1`, `pin_a2_oe`, `sw_do` and `load_done` are 0 and `station_addr` is all zero.
- R2: During the load, the serial clock (`pin_a0`) holds each level for exactly SK_HALF clock cycles. Before every word, `ee_cs` stays low for two half periods with the clock low, and the first half period after reset is part of that gap.
- R3: Each word frame drives `pin_a1` with the bits 1, 1, 0 (start bit, then read opcode), followed by the word address MSB first. The address is 6 bits wide when the strap was 0 and 8 bits wide when it was 1. The words are read at addresses 0, 1, 2 in that order, and `pin_a1` stays stable while the clock is high.
- R4: After the address, `pin_a1` is 0 for one dummy slot and 16 data slots. `pin_a2_i` is sampled in the clock cycle where the serial clock rises. The dummy bit is discarded and the data is taken MSB first.
- R5: The word read from address k lands in `station_addr[16k+15:16k]`. After `load_done` it does not change.
- R6: `load_done` rises in the clock cycle in which the last high half period of the last frame ends, and it stays high until reset.
- R7: Until `load_done`, `pin_a2_oe` and `sw_do` are 0, and the values of `mem_addr_lo`, `sw_en`, `sw_cs`, `sw_sk` and `sw_di` have no effect on any output.
- R8: After `load_done` with `sw_en` low, `pin_a0`, `pin_a1` and `pin_a2_o` equal `mem_addr_lo[0]`, `[1]` and `[2]`, `pin_a2_oe` is 1, and `ee_cs` and `sw_do` are 0.
- R9: After `load_done` with `sw_en` high, `ee_cs`=`sw_cs`, `pin_a0`=`sw_sk`, `pin_a1`=`sw_di`, `pin_a2_oe`=0 and `sw_do`=`pin_a2_i`.
- R10: The strap `size_4k` is captured only while `rst` is high. Changing it during a load does not alter the address width of that load.
- R11: Asserting `rst` part-way through a load abandons it. The next load starts again from the first gap of word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts a new load when released |
| size_4k | input | 1 | Device size strap: 0 selects 6 address bits, 1 selects 8 |
| mem_addr_lo | input | 3 | Packet-memory address bits 2:0 from the memory arbiter |
| sw_en | input | 1 | Hands the serial lines to software after the load |
| sw_cs | input | 1 | Software-driven memory select |
| sw_sk | input | 1 | Software-driven serial clock |
| sw_di | input | 1 | Software-driven serial data towards the memory |
| sw_do | output | 1 | Serial data from the memory, as seen by software |
| pin_a2_i | input | 1 | Input side of shared pin 2 (serial data from the memory) |
| pin_a0 | output | 1 | Shared pin 0: serial clock or address bit 0 |
| pin_a1 | output | 1 | Shared pin 1: serial data out or address bit 1 |
| pin_a2_o | output | 1 | Output side of shared pin 2: address bit 2 |
| pin_a2_oe | output | 1 | Output enable of shared pin 2 |
| ee_cs | output | 1 | Serial memory select |
| load_done | output | 1 | Load complete; address pins may be used |
| station_addr | output | 48 | Loaded words, word k in bits 16k+15:16k |

## Verification
The hardest case to reach is a frame whose address width differs from what the current strap value would give. This needs a strap change in the middle of a load, followed by a check that every remaining slot still follows the width captured at reset. A second hard case is a load cut short and then restarted. The stimulus covers both. One load is aborted by reset at an arbitrary cycle and the next starts with the opposite strap, which is then flipped mid-frame. All the while the arbiter address and the software lines toggle every cycle, and a behavioural serial memory in the bench answers from its own decoding of the command bits.

// File: rtl/eeprom_cfg_pkg.sv
package eeprom_cfg_pkg;

    localparam int CMD_BITS     = 3;
    localparam int ADDR_W_SMALL = 6;
    localparam int ADDR_W_LARGE = 8;

    typedef enum logic [1:0] {
        PH_GAP  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_DONE = 2'd3
    } ee_phase_e;

    typedef enum logic [1:0] {
        PM_LOAD = 2'd0,
        PM_MEM  = 2'd1,
        PM_SOFT = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } ee_lines_t;

    function automatic int addr_width(input logic wide);
        return wide ? ADDR_W_LARGE : ADDR_W_SMALL;
    endfunction

    function automatic int frame_len(input int aw, input int word_w);
        return CMD_BITS + aw + 1 + word_w;
    endfunction

    // Serial data-in value for slot n of a frame reading word address wa
    function automatic logic frame_di(input int n, input int aw, input int wa);
        if (n < 2)
            return 1'b1;
        else if (n == 2)
            return 1'b0;
        else if (n < CMD_BITS + aw)
            return ((wa >> (aw - 1 - (n - CMD_BITS))) & 1) != 0;
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/ee_half_timer.sv
module ee_half_timer #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ee_read_seq.sv
module ee_read_seq
    import eeprom_cfg_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 16,
    parameter int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wide,
    input  logic              do_in,
    output ee_lines_t         lines,
    output logic              word_valid,
    output logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] word_data,
    output logic              done
);
    localparam int MAX_NB = frame_len(ADDR_W_LARGE, WORD_W);
    localparam int BIT_W  = $clog2(MAX_NB + 1);

    ee_phase_e         phase;
    logic [BIT_W-1:0]  bit_idx;
    logic              gap_second;
    logic [WORD_W-1:0] shreg;

    int   aw;
    int   nb;
    logic last_bit;
    logic data_slot;

    always_comb begin
        aw        = addr_width(wide);
        nb        = frame_len(aw, WORD_W);
        last_bit  = (int'(bit_idx) == nb - 1);
        data_slot = (int'(bit_idx) >= CMD_BITS + aw + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_GAP;
            bit_idx    <= '0;
            word_idx   <= '0;
            gap_second <= 1'b0;
            shreg      <= '0;
        end else if (tick) begin
            case (phase)
                PH_GAP: begin
                    if (gap_second) begin
                        gap_second <= 1'b0;
                        bit_idx    <= '0;
                        phase      <= PH_LOW;
                    end else begin
                        gap_second <= 1'b1;
                    end
                end
                PH_LOW: begin
                    phase <= PH_HIGH;
                    if (data_slot)
                        shreg <= {shreg[WORD_W-2:0], do_in};
                end
                PH_HIGH: begin
                    if (last_bit) begin
                        if (int'(word_idx) == NUM_WORDS - 1) begin
                            phase <= PH_DONE;
                        end else begin
                            word_idx <= word_idx + 1'b1;
                            phase    <= PH_GAP;
                        end
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        phase   <= PH_LOW;
                    end
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

    always_comb begin
        lines.cs   = (phase == PH_LOW) || (phase == PH_HIGH);
        lines.sk   = (phase == PH_HIGH);
        lines.di   = lines.cs && frame_di(int'(bit_idx), aw, int'(word_idx));
        word_valid = tick && (phase == PH_HIGH) && last_bit;
        word_data  = shreg;
        done       = (phase == PH_DONE);
    end
endmodule

// File: rtl/ee_pin_mux.sv
module ee_pin_mux
    import eeprom_cfg_pkg::*;
(
    input  logic       done,
    input  logic       sw_en,
    input  ee_lines_t  lines,
    input  logic [2:0] mem_addr_lo,
    input  logic       sw_cs,
    input  logic       sw_sk,
    input  logic       sw_di,
    input  logic       pin_a2_i,
    output logic       pin_a0,
    output logic       pin_a1,
    output logic       pin_a2_o,
    output logic       pin_a2_oe,
    output logic       ee_cs,
    output logic       sw_do
);
    pin_mode_e mode;

    always_comb begin
        if (!done)
            mode = PM_LOAD;
        else if (sw_en)
            mode = PM_SOFT;
        else
            mode = PM_MEM;

        pin_a0    = 1'b0;
        pin_a1    = 1'b0;
        pin_a2_o  = 1'b0;
        pin_a2_oe = 1'b0;
        ee_cs     = 1'b0;
        sw_do     = 1'b0;
        case (mode)
            PM_LOAD: begin
                pin_a0 = lines.sk;
                pin_a1 = lines.di;
                ee_cs  = lines.cs;
            end
            PM_MEM: begin
                pin_a0    = mem_addr_lo[0];
                pin_a1    = mem_addr_lo[1];
                pin_a2_o  = mem_addr_lo[2];
                pin_a2_oe = 1'b1;
            end
            PM_SOFT: begin
                pin_a0 = sw_sk;
                pin_a1 = sw_di;
                ee_cs  = sw_cs;
                sw_do  = pin_a2_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
    import eeprom_cfg_pkg::*;
#(
    parameter int SK_HALF   = 4,
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          size_4k,
    input  logic [2:0]                    mem_addr_lo,
    input  logic                          sw_en,
    input  logic                          sw_cs,
    input  logic                          sw_sk,
    input  logic                          sw_di,
    output logic                          sw_do,
    input  logic                          pin_a2_i,
    output logic                          pin_a0,
    output logic                          pin_a1,
    output logic                          pin_a2_o,
    output logic                          pin_a2_oe,
    output logic                          ee_cs,
    output logic                          load_done,
    output logic [NUM_WORDS*WORD_W-1:0]   station_addr
);
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic              wide_q;
    logic              tick;
    ee_lines_t         lines;
    logic              word_valid;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] word_data;
    logic              seq_done;
    logic [WORD_W-1:0] slot_q [NUM_WORDS];

    // R10: strap captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst)
            wide_q <= size_4k;
    end

    ee_half_timer #(.HALF(SK_HALF)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    ee_read_seq #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .wide       (wide_q),
        .do_in      (pin_a2_i),
        .lines      (lines),
        .word_valid (word_valid),
        .word_idx   (word_idx),
        .word_data  (word_data),
        .done       (seq_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_WORDS; k++)
                slot_q[k] <= '0;
        end else if (word_valid) begin
            for (int k = 0; k < NUM_WORDS; k++)
                if (int'(word_idx) == k)
                    slot_q[k] <= word_data;
        end
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_station
        assign station_addr[g*WORD_W +: WORD_W] = slot_q[g];
    end

    assign load_done = seq_done;

    ee_pin_mux u_mux (
        .done        (seq_done),
        .sw_en       (sw_en),
        .lines       (lines),
        .mem_addr_lo (mem_addr_lo),
        .sw_cs       (sw_cs),
        .sw_sk       (sw_sk),
        .sw_di       (sw_di),
        .pin_a2_i    (pin_a2_i),
        .pin_a0      (pin_a0),
        .pin_a1      (pin_a1),
        .pin_a2_o    (pin_a2_o),
        .pin_a2_oe   (pin_a2_oe),
        .ee_cs       (ee_cs),
        .sw_do       (sw_do)
    );
endmodule

// File: rtl/eeprom_cfg_loader_chk.sv
module eeprom_cfg_loader_chk #(
    parameter int SK_HALF = 4,
    parameter int OUT_W   = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             pin_a0,
    input logic             pin_a1,
    input logic             pin_a2_oe,
    input logic             ee_cs,
    input logic             sw_do,
    input logic             load_done,
    input logic [OUT_W-1:0] station_addr
);
    int   run;
    logic sk_q;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 0;
            sk_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            sk_q   <= pin_a0;
            done_q <= load_done;
            run    <= (pin_a0 != sk_q) ? 1 : run + 1;
        end
    end

    // R7: pin 2 never driven and no software readback before the load ends
    p_pin2_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !load_done |-> (!pin_a2_oe && !sw_do));

    // R6: the done flag is sticky
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        load_done |=> load_done);

    // R2: serial clock high phase lasts SK_HALF cycles
    p_sk_high_len_r2: assert property (@(posedge clk) disable iff (rst)
        (sk_q && !pin_a0 && !done_q) |-> (run == SK_HALF));

    // R2: select stays low more than one cycle between frames
    p_cs_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_done && $fell(ee_cs)) |=> !ee_cs);

    // R3: data towards the memory is stable while the clock is high
    p_di_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_done && pin_a0 && $past(pin_a0)) |-> (pin_a1 == $past(pin_a1)));

    // R5: loaded words hold after completion
    p_station_hold_r5: assert property (@(posedge clk) disable iff (rst)
        load_done |=> $stable(station_addr));
endmodule

bind eeprom_cfg_loader eeprom_cfg_loader_chk #(
    .SK_HALF (SK_HALF),
    .OUT_W   (NUM_WORDS*WORD_W)
) u_chk (.*);

// File: tb/eeprom_cfg_loader_test.sv
module eeprom_cfg_loader_test;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        size_4k = 1'b0;
    logic [2:0]  mem_addr_lo = '0;
    logic        sw_en = 1'b0, sw_cs = 1'b0, sw_sk = 1'b0, sw_di = 1'b0;
    logic        pin_a2_i = 1'b1;
    logic        sw_do, pin_a0, pin_a1, pin_a2_o, pin_a2_oe, ee_cs, load_done;
    logic [47:0] station_addr;

    int checks = 0;
    int errors = 0;

    // behavioural memory model state
    int   rises;
    int   cmd_val;
    int   words_seen;
    logic sk_prev;
    logic cs_prev;
    int   run_aw;

    always #10 clk = ~clk;

    eeprom_cfg_loader uut (
        .clk(clk), .rst(rst), .size_4k(size_4k), .mem_addr_lo(mem_addr_lo),
        .sw_en(sw_en), .sw_cs(sw_cs), .sw_sk(sw_sk), .sw_di(sw_di), .sw_do(sw_do),
        .pin_a2_i(pin_a2_i), .pin_a0(pin_a0), .pin_a1(pin_a1), .pin_a2_o(pin_a2_o),
        .pin_a2_oe(pin_a2_oe), .ee_cs(ee_cs), .load_done(load_done),
        .station_addr(station_addr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] rom_word(input int a);
        return 16'hA55A ^ 16'(a * 3889);
    endfunction

    function automatic logic exp_di(input int n, input int aw, input int w);
        if (n < 2) return 1'b1;
        if (n == 2) return 1'b0;
        if (n < 3 + aw) return 1'(((w >> (aw - 1 - (n - 3))) & 1));
        return 1'b0;
    endfunction

    // memory model: reacts to pins seen after the latest rising clock edge
    task automatic model_step();
        int n;
        if (!ee_cs) begin
            if (cs_prev) words_seen++;
            rises   = 0;
            cmd_val = 0;
        end else if (pin_a0 && !sk_prev) begin
            if (rises < 3 + run_aw) cmd_val = cmd_val * 2 + int'(pin_a1);
            rises++;
            if (rises == 3 + run_aw) begin
                chk((cmd_val >> run_aw) == 6, "R3 opcode", cmd_val >> run_aw, 6);
                chk((cmd_val & ((1 << run_aw) - 1)) == words_seen, "R3 word address",
                    cmd_val & ((1 << run_aw) - 1), words_seen);
            end
        end
        sk_prev = pin_a0;
        cs_prev = ee_cs;
        n = rises;
        if (n == 3 + run_aw)
            pin_a2_i = 1'b0;
        else if (n >= 4 + run_aw && n < 20 + run_aw)
            pin_a2_i = rom_word(cmd_val & ((1 << run_aw) - 1))[15 - (n - 4 - run_aw)];
        else
            pin_a2_i = 1'b1;
    endtask

    // one load; abort_at < 0 runs to completion, flip_at >= 0 toggles the strap there
    task automatic run_load(input logic wide, input int abort_at, input int flip_at,
                            input bit restart);
        int nb, per, total;
        @(negedge clk);
        rst = 1'b1;
        size_4k = wide;
        sw_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ee_cs && !pin_a0 && !pin_a1 && !pin_a2_oe && !sw_do && !load_done,
            "R1 pins in reset", {ee_cs, pin_a0, pin_a1, pin_a2_oe, sw_do, load_done}, 0);
        chk(station_addr == 48'h0, "R1 station in reset", station_addr, 0);
        run_aw = wide ? 8 : 6;
        nb = 20 + run_aw;
        per = 2 + 2 * nb;
        total = 3 * per * H;
        rises = 0; cmd_val = 0; words_seen = 0; sk_prev = 1'b0; cs_prev = 1'b0;
        pin_a2_i = 1'b1;
        rst = 1'b0;
        for (int k = 0; k <= total + 5; k++) begin
            int slot, w, r, n;
            logic ecs, esk, edi, edone;
            if (k > 0) @(negedge clk);
            model_step();
            slot = k / H;
            if (slot < 3 * per) begin
                w = slot / per;
                r = slot % per;
                edone = 1'b0;
                if (r < 2) begin
                    ecs = 1'b0; esk = 1'b0; edi = 1'b0;
                end else begin
                    n = (r - 2) / 2;
                    ecs = 1'b1; esk = 1'((r - 2) % 2); edi = exp_di(n, run_aw, w);
                end
            end else begin
                ecs = 1'b0; esk = 1'b0; edi = 1'b0; edone = 1'b1;
            end
            chk(ee_cs == ecs, "R2 select", ee_cs, ecs);
            chk(pin_a0 == esk, "R2 serial clock", pin_a0, esk);
            chk(pin_a1 == edi, "R3 serial data out", pin_a1, edi);
            chk(load_done == edone, "R6 done timing", load_done, edone);
            if (!edone)
                chk(!pin_a2_oe && !sw_do, "R7 pin2 idle during load", {pin_a2_oe, sw_do}, 0);
            if (restart && k == 2 * H)
                chk(ee_cs == 1'b1, "R11 restart from first frame", ee_cs, 1);
            if (k == abort_at) return;
            if (k == flip_at) size_4k = ~size_4k;
            // R7: noise on ignored inputs while loading
            if (k + 1 < total) begin
                mem_addr_lo = 3'(k);
                sw_en = k[3]; sw_cs = k[0]; sw_sk = k[1]; sw_di = k[2];
            end else begin
                mem_addr_lo = '0;
                sw_en = 1'b0; sw_cs = 1'b0; sw_sk = 1'b0; sw_di = 1'b0;
            end
        end
        chk(station_addr[15:0] == rom_word(0), "R4 first word", station_addr[15:0], rom_word(0));
        chk(station_addr == {rom_word(2), rom_word(1), rom_word(0)},
            flip_at >= 0 ? "R10 strap change ignored, R5 placement" : "R5 placement",
            station_addr, {rom_word(2), rom_word(1), rom_word(0)});
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run_load(1'b0, 150, -1, 1'b0);
        run_load(1'b1, -1, 100, 1'b1);
        run_load(1'b0, -1, -1, 1'b0);

        // R8: address pass-through after completion
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            sw_en = 1'b0;
            mem_addr_lo = 3'(p);
            pin_a2_i = p[0];
            #1;
            chk({pin_a2_o, pin_a1, pin_a0} == 3'(p), "R8 address bits", {pin_a2_o, pin_a1, pin_a0}, p);
            chk(pin_a2_oe && !ee_cs && !sw_do, "R8 pin2 driven, select low",
                {pin_a2_oe, ee_cs, sw_do}, 3'b100);
        end
        // R9: software bit-bang access
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            sw_en = 1'b1;
            mem_addr_lo = 3'(~p);
            sw_cs = p[0]; sw_sk = p[1]; sw_di = p[2]; pin_a2_i = p[3];
            #1;
            chk({ee_cs, pin_a0, pin_a1, sw_do} == {p[0], p[1], p[2], p[3]}, "R9 software lines",
                {ee_cs, pin_a0, pin_a1, sw_do}, {p[0], p[1], p[2], p[3]});
            chk(!pin_a2_oe, "R9 pin2 released", pin_a2_oe, 0);
        end
        chk(load_done, "R6 done stays high", load_done, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule